// File: doc/BRIEF.md
# LPDDR Power-Up Initialization Sequencer

This block sits on the controller side of a mobile low-power DDR SDRAM. It takes the memory from power-on to a ready state. Once reset is released it raises the clock-enable line, then keeps the command bus quiet for the mandatory power-up settle time. After that it issues a fixed run of commands: a precharge of all banks, two auto-refreshes, and a write to each of the two mode registers. The refreshes can come before or after the mode writes. Between any two commands it counts out the minimum spacing, derived from a clock-period parameter and the device timing parameters, and keeps the bus at NOP during that wait.

The two mode-register values come in on input ports. A configuration bit, captured while reset is held, chooses which register is written first. When the final wait has run out, `init_done` rises and stays high. Any power-down or clock-stop request is refused until then. A synchronous reset at any time abandons the sequence and starts it again from the power-up wait.

Top module: `lpddr_init_seq`

## Requirements
- R1: While `rst_n` is sampled low, the block drives `cke` low, holds the bus at NOP ({cs_n,ras_n,cas_n,we_n} = 0111, `addr` = 0, `ba` = 0), and keeps `init_done` and `pd_grant` low.
- R2: `cke` goes high in the first cycle after reset is released and stays high until the next reset.
- R3: The first command is PRECHARGE ALL, encoded 0010 with `addr[10]` = 1, all other address bits 0 and `ba` = 0. It appears exactly CYC_PWR = ceil(T_PWRUP_PS / CLK_PERIOD_PS) cycles after the cycle in which `cke` first goes high. Every cycle in between is NOP.
- R4: The command after PRECHARGE ALL comes exactly CYC_RP = ceil(T_RP_PS / CLK_PERIOD_PS) cycles after it. Spacing here and below counts cycles from one command's cycle to the next command's cycle, and all cycles in between are NOP.
- R5: Exactly two AUTO REFRESH commands are issued (0001, `addr` = 0, `ba` = 0). Each is followed by exactly CYC_RFC = ceil(T_RFC_PS / CLK_PERIOD_PS) cycles before the next command or completion.
- R6: The base mode register is written with 0000, `ba` = 00 and `addr` = `base_mode`. The extended register is written with 0000, `ba` = 10 and `addr` = `ext_mode`. Each write is followed by exactly CYC_MRD = ceil(T_MRD_PS / CLK_PERIOD_PS) cycles before the next command or completion.
- R7: If `ext_first` was 0 while reset was held, the base register is written before the extended one. If it was 1, the extended register is written first.
- R8: With REFRESH_LAST = 0, both refreshes come between the precharge and the mode writes. With REFRESH_LAST = 1, they come after both mode writes.
- R9: `init_done` rises exactly one full wait after the last command: CYC_MRD after a mode write, CYC_RFC after a refresh. It then stays high, and no further command appears until reset.
- R10: `pd_grant` is high exactly when `pd_req` and `init_done` are both high. A request held through the sequence is refused in every cycle before completion and granted in the very cycle `init_done` rises.
- R11: A reset asserted in the middle of the sequence restarts it completely, including the full power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset; restarts the sequence |
| ext_first | input | 1 | Mode-write order, captured during reset (1 = extended first) |
| base_mode | input | ADDR_W | Value written to the base mode register |
| ext_mode | input | ADDR_W | Value written to the extended mode register |
| pd_req | input | 1 | Power-down / clock-stop request |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus (mode value or precharge-all flag) |
| ba | output | BA_W | Bank address (mode register select) |
| init_done | output | 1 | Device ready for any valid command |
| pd_grant | output | 1 | Power-down request accepted |

## Verification
Completion of the last wait and the power-down hand-off land in the same cycle. The request input is held high from reset through the end of every run. The bench therefore requires the grant to stay low in every cycle before the final wait expires and to rise in exactly the cycle `init_done` first rises. A second collision is a reset arriving partway through a refresh or mode wait. After it, the bench expects the counters to drop the half-finished wait and to replay the whole sequence, starting with a full power-up delay measured from the new `cke` rise. Both refresh placements run side by side on the same stimulus, and a scoreboard of expected commands and spacings is kept for each placement.

// File: rtl/lpdi_pkg.sv
`timescale 1ns/1ps
package lpdi_pkg;

   typedef enum logic [2:0] {
      OP_NOP      = 3'd0,
      OP_PREA     = 3'd1,
      OP_REF      = 3'd2,
      OP_MRS_BASE = 3'd3,
      OP_MRS_EXT  = 3'd4
   } op_e;

   // {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] ENC_NOP = 4'b0111;
   localparam logic [3:0] ENC_PRE = 4'b0010;
   localparam logic [3:0] ENC_REF = 4'b0001;
   localparam logic [3:0] ENC_MRS = 4'b0000;

   // precharge, two refreshes, two mode writes
   localparam int NUM_STEPS = 5;

   function automatic int ps_to_cycles(input int t_ps, input int tck_ps);
      int c;
      c = (t_ps + tck_ps - 1) / tck_ps;
      if (c < 1) c = 1;
      return c;
   endfunction

endpackage

// File: rtl/lpdi_wait_counter.sv
`timescale 1ns/1ps
module lpdi_wait_counter #(
   parameter int CNT_W   = 16,
   parameter int RST_VAL = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= CNT_W'(RST_VAL);
      else if (load)
         cnt_q <= load_val;
      else if (run && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/lpdi_step_rom.sv
`timescale 1ns/1ps
module lpdi_step_rom
   import lpdi_pkg::*;
#(
   parameter int STEP_W       = 3,
   parameter int REFRESH_LAST = 0
) (
   input  logic [STEP_W-1:0] step,
   input  logic              ext_first,
   output op_e               op
);
   op_e mr_a, mr_b;

   assign mr_a = ext_first ? OP_MRS_EXT  : OP_MRS_BASE;
   assign mr_b = ext_first ? OP_MRS_BASE : OP_MRS_EXT;

   generate
      if (REFRESH_LAST == 0) begin : g_ref_early
         always_comb begin
            case (step)
               STEP_W'(0): op = OP_PREA;
               STEP_W'(1): op = OP_REF;
               STEP_W'(2): op = OP_REF;
               STEP_W'(3): op = mr_a;
               STEP_W'(4): op = mr_b;
               default:    op = OP_NOP;
            endcase
         end
      end else begin : g_ref_late
         always_comb begin
            case (step)
               STEP_W'(0): op = OP_PREA;
               STEP_W'(1): op = mr_a;
               STEP_W'(2): op = mr_b;
               STEP_W'(3): op = OP_REF;
               STEP_W'(4): op = OP_REF;
               default:    op = OP_NOP;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/lpdi_cmd_encoder.sv
`timescale 1ns/1ps
module lpdi_cmd_encoder
   import lpdi_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int BA_W   = 2
) (
   input  op_e               op,
   input  logic [ADDR_W-1:0] base_mode,
   input  logic [ADDR_W-1:0] ext_mode,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   ba
);
   localparam int AP_BIT  = 10;
   localparam int EXT_BIT = 1;

   always_comb begin
      {cs_n, ras_n, cas_n, we_n} = ENC_NOP;
      addr = '0;
      ba   = '0;
      case (op)
         OP_PREA: begin
            {cs_n, ras_n, cas_n, we_n} = ENC_PRE;
            addr[AP_BIT] = 1'b1;
         end
         OP_REF: {cs_n, ras_n, cas_n, we_n} = ENC_REF;
         OP_MRS_BASE: begin
            {cs_n, ras_n, cas_n, we_n} = ENC_MRS;
            addr = base_mode;
         end
         OP_MRS_EXT: begin
            {cs_n, ras_n, cas_n, we_n} = ENC_MRS;
            addr        = ext_mode;
            ba[EXT_BIT] = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/lpddr_init_seq.sv
`timescale 1ns/1ps
module lpddr_init_seq
   import lpdi_pkg::*;
#(
   parameter int CLK_PERIOD_PS = 10000,
   parameter int T_PWRUP_PS    = 200_000_000,
   parameter int T_RP_PS       = 18000,
   parameter int T_RFC_PS      = 72000,
   parameter int T_MRD_PS      = 12000,
   parameter int ADDR_W        = 13,
   parameter int BA_W          = 2,
   parameter int REFRESH_LAST  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_first,
   input  logic [ADDR_W-1:0] base_mode,
   input  logic [ADDR_W-1:0] ext_mode,
   input  logic              pd_req,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   ba,
   output logic              init_done,
   output logic              pd_grant
);
   localparam int CYC_PWR  = ps_to_cycles(T_PWRUP_PS, CLK_PERIOD_PS);
   localparam int CYC_RP   = ps_to_cycles(T_RP_PS,    CLK_PERIOD_PS);
   localparam int CYC_RFC  = ps_to_cycles(T_RFC_PS,   CLK_PERIOD_PS);
   localparam int CYC_MRD  = ps_to_cycles(T_MRD_PS,   CLK_PERIOD_PS);
   localparam int MAX_SHORT = (CYC_RP > CYC_RFC)
                              ? ((CYC_RP > CYC_MRD) ? CYC_RP : CYC_MRD)
                              : ((CYC_RFC > CYC_MRD) ? CYC_RFC : CYC_MRD);
   localparam int CNT_MAX  = (CYC_PWR > MAX_SHORT) ? CYC_PWR : MAX_SHORT;
   localparam int CNT_W    = $clog2(CNT_MAX + 1);
   localparam int STEP_W   = $clog2(NUM_STEPS + 1);

   // elaboration-time parameter checks
   generate
      if (CLK_PERIOD_PS <= 0) begin : g_bad_clk
         $error("lpddr_init_seq: CLK_PERIOD_PS must be positive");
      end
      if (ADDR_W < 11) begin : g_bad_addr
         $error("lpddr_init_seq: ADDR_W must reach the all-bank bit");
      end
      if (BA_W < 2) begin : g_bad_ba
         $error("lpddr_init_seq: BA_W must be at least 2");
      end
      if ((REFRESH_LAST != 0) && (REFRESH_LAST != 1)) begin : g_bad_order
         $error("lpddr_init_seq: REFRESH_LAST must be 0 or 1");
      end
   endgenerate

   logic              cke_q;
   logic              ext_first_q;
   logic [STEP_W-1:0] step_q;
   logic              cnt_zero;
   logic              issue;
   op_e               op_step;
   op_e               op_now;
   int                wait_len;
   logic [CNT_W-1:0]  load_val;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cke_q       <= 1'b0;
         ext_first_q <= ext_first;
         step_q      <= '0;
      end else begin
         cke_q <= 1'b1;
         if (issue) step_q <= step_q + 1'b1;
      end
   end

   assign issue = cke_q && cnt_zero && (step_q < STEP_W'(NUM_STEPS));

   lpdi_step_rom #(
      .STEP_W       (STEP_W),
      .REFRESH_LAST (REFRESH_LAST)
   ) u_step_rom (
      .step      (step_q),
      .ext_first (ext_first_q),
      .op        (op_step)
   );

   always_comb begin
      case (op_step)
         OP_PREA:                 wait_len = CYC_RP;
         OP_REF:                  wait_len = CYC_RFC;
         OP_MRS_BASE, OP_MRS_EXT: wait_len = CYC_MRD;
         default:                 wait_len = 1;
      endcase
   end

   assign load_val = CNT_W'(wait_len - 1);

   lpdi_wait_counter #(
      .CNT_W   (CNT_W),
      .RST_VAL (CYC_PWR)
   ) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (cke_q),
      .load     (issue),
      .load_val (load_val),
      .zero     (cnt_zero)
   );

   assign op_now = issue ? op_step : OP_NOP;

   lpdi_cmd_encoder #(
      .ADDR_W (ADDR_W),
      .BA_W   (BA_W)
   ) u_enc (
      .op        (op_now),
      .base_mode (base_mode),
      .ext_mode  (ext_mode),
      .cs_n      (cs_n),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .we_n      (we_n),
      .addr      (addr),
      .ba        (ba)
   );

   assign cke       = cke_q;
   assign init_done = cke_q && cnt_zero && (step_q == STEP_W'(NUM_STEPS));
   assign pd_grant  = pd_req && init_done;
endmodule

// File: rtl/lpdi_checker.sv
`timescale 1ns/1ps
module lpdi_checker #(
   parameter int BA_W    = 2,
   parameter int CYC_RP  = 1,
   parameter int CYC_RFC = 1,
   parameter int CYC_MRD = 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cke,
   input logic            cs_n,
   input logic            ras_n,
   input logic            cas_n,
   input logic            we_n,
   input logic [BA_W-1:0] ba,
   input logic            init_done
);
   logic [3:0] enc;
   logic [1:0] kind_now;   // 0 none, 1 precharge, 2 refresh, 3 mode write
   logic [1:0] last_kind;
   int         gap;
   int         min_req;
   logic [1:0] ref_cnt;
   logic       seen_base;
   logic       seen_ext;

   assign enc = {cs_n, ras_n, cas_n, we_n};

   always_comb begin
      case (enc)
         4'b0010: kind_now = 2'd1;
         4'b0001: kind_now = 2'd2;
         4'b0000: kind_now = 2'd3;
         default: kind_now = 2'd0;
      endcase
   end

   always_comb begin
      case (last_kind)
         2'd1:    min_req = CYC_RP;
         2'd2:    min_req = CYC_RFC;
         2'd3:    min_req = CYC_MRD;
         default: min_req = 0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap       <= 0;
         last_kind <= 2'd0;
         ref_cnt   <= 2'd0;
         seen_base <= 1'b0;
         seen_ext  <= 1'b0;
      end else begin
         if (kind_now != 2'd0) begin
            gap       <= 1;
            last_kind <= kind_now;
         end else if (gap < 32'h0010_0000) begin
            gap <= gap + 1;
         end
         if (kind_now == 2'd2 && ref_cnt != 2'd3) ref_cnt <= ref_cnt + 1'b1;
         if (kind_now == 2'd3 && ba[1:0] == 2'b00) seen_base <= 1'b1;
         if (kind_now == 2'd3 && ba[1:0] == 2'b10) seen_ext  <= 1'b1;
      end
   end

   AST_NOP_WHILE_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> (enc == 4'b0111)); // R1
   AST_CKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> cke); // R2
   AST_FIRST_IS_PREA: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_now != 2'd0 && last_kind == 2'd0) |-> (kind_now == 2'd1)); // R3
   AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_now != 2'd0 && last_kind != 2'd0) |-> (gap >= min_req)); // R4
   AST_TWO_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> (ref_cnt == 2'd2)); // R5
   AST_BOTH_MODES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> (seen_base && seen_ext)); // R6
   AST_MRS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_now == 2'd3) |-> (ba[1:0] == 2'b00 || ba[1:0] == 2'b10)); // R6
   AST_DONE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> (gap >= min_req)); // R9
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done); // R9
   AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (enc == 4'b0111)); // R9
endmodule

bind lpddr_init_seq lpdi_checker #(
   .BA_W    (BA_W),
   .CYC_RP  (CYC_RP),
   .CYC_RFC (CYC_RFC),
   .CYC_MRD (CYC_MRD)
) u_lpdi_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cke       (cke),
   .cs_n      (cs_n),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .we_n      (we_n),
   .ba        (ba),
   .init_done (init_done)
);

// File: tb/test_lpddr_init_seq.sv
`timescale 1ns/1ps
module test_lpddr_init_seq;
   localparam int TCK_PS     = 10000;
   localparam int T_PWRUP_PS = 200_000_000;
   localparam int T_RP_PS    = 18000;
   localparam int T_RFC_PS   = 72000;
   localparam int T_MRD_PS   = 12000;
   localparam int ADDR_W     = 13;
   localparam int BA_W       = 2;

   localparam int CYC_PWR = (T_PWRUP_PS + TCK_PS - 1) / TCK_PS;
   localparam int CYC_RP  = (T_RP_PS    + TCK_PS - 1) / TCK_PS;
   localparam int CYC_RFC = (T_RFC_PS   + TCK_PS - 1) / TCK_PS;
   localparam int CYC_MRD = (T_MRD_PS   + TCK_PS - 1) / TCK_PS;

   typedef struct {
      logic [3:0]        enc;
      logic [BA_W-1:0]   ba;
      logic [ADDR_W-1:0] addr;
      int                gap;
      bit                done;
      string             tag;
   } exp_t;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic              rst_n = 1'b0;
   logic              ext_first = 1'b0;
   logic              pd_req = 1'b1;
   logic [ADDR_W-1:0] base_mode = '0;
   logic [ADDR_W-1:0] ext_mode = '0;
   logic              rst_seen = 1'b0;
   int                n_tests = 0;
   int                n_fail = 0;

   always @(posedge clk) rst_seen <= rst_n;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   for (genvar g = 0; g < 2; g++) begin : g_v
      logic              cke, cs_n, ras_n, cas_n, we_n, init_done, pd_grant;
      logic [ADDR_W-1:0] addr;
      logic [BA_W-1:0]   ba;
      exp_t              exp_q[$];
      int                cyc = 0;
      int                last_evt = 0;
      logic              cke_prev = 1'b0;
      logic              done_prev = 1'b0;

      lpddr_init_seq #(
         .CLK_PERIOD_PS (TCK_PS),
         .T_PWRUP_PS    (T_PWRUP_PS),
         .T_RP_PS       (T_RP_PS),
         .T_RFC_PS      (T_RFC_PS),
         .T_MRD_PS      (T_MRD_PS),
         .ADDR_W        (ADDR_W),
         .BA_W          (BA_W),
         .REFRESH_LAST  (g)
      ) i_lpddr_init_seq (
         .clk       (clk),
         .rst_n     (rst_n),
         .ext_first (ext_first),
         .base_mode (base_mode),
         .ext_mode  (ext_mode),
         .pd_req    (pd_req),
         .cke       (cke),
         .cs_n      (cs_n),
         .ras_n     (ras_n),
         .cas_n     (cas_n),
         .we_n      (we_n),
         .addr      (addr),
         .ba        (ba),
         .init_done (init_done),
         .pd_grant  (pd_grant)
      );

      // monitor: pops the scoreboard as commands appear on the bus
      always @(negedge clk) begin : mon
         exp_t       e;
         logic [3:0] enc;
         cyc = cyc + 1;
         enc = {cs_n, ras_n, cas_n, we_n};
         if (!rst_seen) begin
            cke_prev  = 1'b0;
            done_prev = 1'b0;
         end else begin
            if (!cke_prev && cke) last_evt = cyc;
            if (cke_prev && !cke) chk(1'b0, "R2", "cke dropped", 0, 1);
            if (enc != 4'b0111) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R9", "command after sequence end", enc, 4'b0111);
               end else begin
                  e = exp_q.pop_front();
                  if (e.done) begin
                     chk(1'b0, "R9", "command where completion due", enc, 4'b0111);
                  end else begin
                     chk(enc == e.enc, e.tag, "command code", enc, e.enc);
                     chk(ba == e.ba, e.tag, "bank address", ba, e.ba);
                     chk(addr == e.addr, e.tag, "address", addr, e.addr);
                     chk(cyc - last_evt == e.gap, e.tag, "spacing",
                         cyc - last_evt, e.gap);
                  end
               end
               last_evt = cyc;
            end
            if (init_done && !done_prev) begin
               if (exp_q.size() == 0 || !exp_q[0].done) begin
                  chk(1'b0, "R9", "early completion, pending items",
                      exp_q.size(), 1);
               end else begin
                  e = exp_q.pop_front();
                  chk(cyc - last_evt == e.gap, "R9", "completion spacing",
                      cyc - last_evt, e.gap);
               end
            end
            if (!init_done && done_prev) chk(1'b0, "R9", "init_done dropped", 0, 1);
            chk(pd_grant == (pd_req && init_done), "R10", "power-down grant",
                pd_grant, pd_req && init_done);
            cke_prev  = cke;
            done_prev = init_done;
         end
      end
   end

   function automatic exp_t mk(input logic [3:0] enc, input logic [BA_W-1:0] ba,
                               input logic [ADDR_W-1:0] addr, input int gap,
                               input bit done, input string tag);
      exp_t e;
      e.enc = enc; e.ba = ba; e.addr = addr; e.gap = gap; e.done = done; e.tag = tag;
      return e;
   endfunction

   // driver: pushes the expected command stream for both refresh placements
   task automatic push_seq(input bit ef, input logic [ADDR_W-1:0] bm,
                           input logic [ADDR_W-1:0] em, input string pre_tag);
      exp_t pre, rf, m1, m2;
      pre = mk(4'b0010, '0, ADDR_W'(1) << 10, CYC_PWR, 1'b0, pre_tag);
      rf  = mk(4'b0001, '0, '0, 0, 1'b0, "R5");
      m1  = ef ? mk(4'b0000, BA_W'(2), em, 0, 1'b0, "R7")
               : mk(4'b0000, BA_W'(0), bm, 0, 1'b0, "R7");
      m2  = ef ? mk(4'b0000, BA_W'(0), bm, 0, 1'b0, "R6")
               : mk(4'b0000, BA_W'(2), em, 0, 1'b0, "R6");
      // REFRESH_LAST = 0 (R8): precharge, refresh, refresh, mode, mode
      g_v[0].exp_q.push_back(pre);
      rf.gap = CYC_RP;  rf.tag = "R4"; g_v[0].exp_q.push_back(rf);
      rf.gap = CYC_RFC; rf.tag = "R5"; g_v[0].exp_q.push_back(rf);
      m1.gap = CYC_RFC; g_v[0].exp_q.push_back(m1);
      m2.gap = CYC_MRD; g_v[0].exp_q.push_back(m2);
      g_v[0].exp_q.push_back(mk(4'b0111, '0, '0, CYC_MRD, 1'b1, "R9"));
      // REFRESH_LAST = 1 (R8): precharge, mode, mode, refresh, refresh
      g_v[1].exp_q.push_back(pre);
      m1.gap = CYC_RP;  m1.tag = "R4"; g_v[1].exp_q.push_back(m1);
      m2.gap = CYC_MRD; g_v[1].exp_q.push_back(m2);
      rf.gap = CYC_MRD; rf.tag = "R8"; g_v[1].exp_q.push_back(rf);
      rf.gap = CYC_RFC; rf.tag = "R5"; g_v[1].exp_q.push_back(rf);
      g_v[1].exp_q.push_back(mk(4'b0111, '0, '0, CYC_RFC, 1'b1, "R9"));
   endtask

   task automatic flush();
      g_v[0].exp_q.delete();
      g_v[1].exp_q.delete();
   endtask

   task automatic check_reset_state();
      chk(g_v[0].cke == 1'b0 && g_v[1].cke == 1'b0, "R1", "cke in reset",
          {g_v[0].cke, g_v[1].cke}, 0);
      chk({g_v[0].cs_n, g_v[0].ras_n, g_v[0].cas_n, g_v[0].we_n} == 4'b0111 &&
          {g_v[1].cs_n, g_v[1].ras_n, g_v[1].cas_n, g_v[1].we_n} == 4'b0111,
          "R1", "bus in reset",
          {g_v[0].cs_n, g_v[0].ras_n, g_v[0].cas_n, g_v[0].we_n}, 4'b0111);
      chk(g_v[0].addr == '0 && g_v[0].ba == '0 && g_v[1].addr == '0 && g_v[1].ba == '0,
          "R1", "address in reset", g_v[0].addr, 0);
      chk(!g_v[0].init_done && !g_v[1].init_done && !g_v[0].pd_grant && !g_v[1].pd_grant,
          "R1", "done/grant in reset",
          {g_v[0].init_done, g_v[1].init_done, g_v[0].pd_grant, g_v[1].pd_grant}, 0);
   endtask

   task automatic wait_done();
      while (!(g_v[0].init_done === 1'b1 && g_v[1].init_done === 1'b1))
         @(negedge clk);
   endtask

   task automatic finish_run();
      repeat (8) @(negedge clk);
      chk(g_v[0].exp_q.size() == 0, "R9", "pending items, early placement",
          g_v[0].exp_q.size(), 0);
      chk(g_v[1].exp_q.size() == 0, "R9", "pending items, late placement",
          g_v[1].exp_q.size(), 0);
      @(posedge clk); #2 pd_req = 1'b0;
      repeat (3) @(posedge clk);
      #2 pd_req = 1'b1;
      repeat (3) @(posedge clk);
   endtask

   task automatic enter_reset(input bit ef, input logic [ADDR_W-1:0] bm,
                              input logic [ADDR_W-1:0] em);
      @(posedge clk); #2 rst_n = 1'b0;
      ext_first = ef; base_mode = bm; ext_mode = em;
      @(posedge clk); #1 flush();
      repeat (2) @(posedge clk);
      @(negedge clk); check_reset_state();
   endtask

   // watchdog
   initial begin
      repeat (190000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // run 1: base register first, request held from the start (R10)
      enter_reset(1'b0, 13'h0032, 13'h0047);
      push_seq(1'b0, 13'h0032, 13'h0047, "R3");
      @(posedge clk); #2 rst_n = 1'b1;
      wait_done();
      finish_run();

      // run 2: extended register first (R7), new mode values
      enter_reset(1'b1, 13'h1A5C, 13'h0B13);
      push_seq(1'b1, 13'h1A5C, 13'h0B13, "R3");
      @(posedge clk); #2 rst_n = 1'b1;
      wait_done();
      finish_run();

      // run 3: reset in the middle of a wait, then a full replay (R11)
      enter_reset(1'b0, 13'h0123, 13'h1F00);
      push_seq(1'b0, 13'h0123, 13'h1F00, "R3");
      @(posedge clk); #2 rst_n = 1'b1;
      repeat (CYC_PWR + CYC_RP + 3) @(posedge clk);
      enter_reset(1'b0, 13'h0123, 13'h1F00);
      push_seq(1'b0, 13'h0123, 13'h1F00, "R11");
      @(posedge clk); #2 rst_n = 1'b1;
      wait_done();
      finish_run();

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule